// File: doc/BRIEF.md
# Buffered Serial Receive Queue with Trigger and Accept Thresholds

This block is the receive side of a buffered serial channel. Bytes from a deserializer are written into a 16-entry first-in first-out queue by a one-cycle strobe. A processor reads them back through a small register port, and each read of the data register takes one entry out of the queue. Two thresholds are set independently in a control register. The trigger threshold sets the point at which a "trigger reached" flag replaces a plain "data present" flag. The accept threshold sets the point at which the block tells the sender to stop.

A byte that arrives while the queue is full is discarded and latches an overrun flag. That flag lives in a line-status register, and reading the register clears it. The two receive flags are registered. They are recomputed at every clock edge from the occupancy and trigger setting the queue will hold after that edge, so a push, a pop or a change of trigger level shows up in the flags one cycle later, together with the new occupancy.

Register select codes: 0 = receive data (a read removes one entry), 1 = status, 2 = control, 3 = line status.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the status register reads 0x0060, the control and line-status registers read 0, the queue is empty, and `rxReady` is 1.
- R2: The queue holds up to 16 bytes. Reads of register 0 return them in arrival order.
- R3: A byte strobed in while 16 bytes are held is dropped, and bit 0 of the line-status register is set. Fullness is judged before any pop in the same cycle, so a byte that arrives together with a pop of a full queue is also dropped.
- R4: Control bits 7..6 select the trigger level: code 0 = 1, code 1 = 4, code 2 = 8, code 3 = 14 entries.
- R5: When the occupancy is at or above the trigger level, status bit 1 (and `trigFlag`) is 1 and status bit 0 (and `dataFlag`) is 0.
- R6: When the occupancy is below the trigger level, status bit 1 is 0 and status bit 0 is 1 exactly when the queue is not empty.
- R7: `rxReady` is 1 while the occupancy is below the accept limit set by control bits 11..9. Codes 0 to 7 give limits of 15, 1, 4, 6, 8, 10, 12 and 14.
- R8: A read of the line-status register returns its current value and clears it to 0 at that edge. An overrun in the same cycle leaves bit 0 set.
- R9: A read of register 0 while the queue is empty returns 0 and does not change the occupancy. A byte strobed in during that same cycle is still stored.
- R10: Writing the control register makes the flags follow the new trigger level from the next cycle on, with no push or pop.
- R11: Status bits 6..5 are writable holding bits that reset to 1. Writes to every other status bit are ignored.
- R12: The control register reads back bits 11..9 and 7..6 as written. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a received byte is on rxData |
| rxData | input | 8 | Received byte |
| regSel | input | 2 | Register select (0 data, 1 status, 2 control, 3 line status) |
| regRd | input | 1 | Register read strobe (side effects at the clock edge) |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regSel, combinational |
| rxReady | output | 1 | Occupancy is below the accept limit |
| trigFlag | output | 1 | Trigger level reached (mirrors status bit 1) |
| dataFlag | output | 1 | Data present below trigger (mirrors status bit 0) |

## Verification
The bench covers all 32 combinations of trigger code and accept code. For each one it walks the occupancy from 0 to 16 and back down, so any threshold that is off by one or mapped to the wrong code shows up as a flag or ready bit that flips one entry early or late. It pushes a 17th byte into a full queue. A design that stored that byte, or that overwrote the oldest entry, would return a wrong byte later in the drain order. It also hits the collision cases: a push into a full queue while popping (an extra byte would appear), an overrun arriving while line status is being read (the sticky bit would be lost), a read of an empty queue (a garbage byte or a count that wraps below zero), and a trigger change with no traffic (the flags would go stale).

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Register select codes
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_LINE = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  // Field positions
  localparam int TRIG_LSB      = 6;
  localparam int TRIG_W        = 2;
  localparam int ACC_LSB       = 9;
  localparam int ACC_W         = 3;
  localparam int STAT_DR       = 0;
  localparam int STAT_RDF      = 1;
  localparam int STAT_HOLD_LSB = 5;
  localparam int STAT_HOLD_W   = 2;
  localparam int LINE_OVR      = 0;

  // Width used for level comparisons
  localparam int LVL_W = 8;

  function automatic logic [LVL_W-1:0] trigLevel(input logic [TRIG_W-1:0] code);
    logic [LVL_W-1:0] lvl;
    unique case (code)
      2'd0:    lvl = 8'd1;
      2'd1:    lvl = 8'd4;
      2'd2:    lvl = 8'd8;
      default: lvl = 8'd14;
    endcase
    return lvl;
  endfunction

  function automatic logic [LVL_W-1:0] acceptLimit(input logic [ACC_W-1:0] code);
    logic [LVL_W-1:0] lim;
    if (code == '0)
      lim = 8'd15;
    else if (code == 3'd1)
      lim = 8'd1;
    else
      lim = LVL_W'({code, 1'b0});
    return lim;
  endfunction

endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  countNext,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush, doPop;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  // Fullness is judged before the pop of the same cycle
  assign doPush = strobe.push && !full;
  assign doPop  = strobe.pop && !empty;

  always_comb begin
    countNext = count;
    if (doPush && !doPop)
      countNext = count + 1'b1;
    else if (!doPush && doPop)
      countNext = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (doPush)
      mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= advance(wrPtr);
      if (doPop)  rdPtr <= advance(rdPtr);
      count <= countNext;
    end
  end

  assign headData = empty ? '0 : mem[rdPtr];

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R9: popping an empty queue without a push leaves the count alone
  a_r9_empty_pop_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && empty && !strobe.push) |=> $stable(count));

  // R3: a push into a full queue without a pop keeps it full
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full && !strobe.pop) |=> full);

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [DATA_W-1:0] headData,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  countNext,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       strobe,
  output logic [REG_W-1:0]  regRdata,
  output logic              rxReady,
  output logic              trigFlag,
  output logic              dataFlag
);

  logic [TRIG_W-1:0]      trigCode, trigCodeNext;
  logic [ACC_W-1:0]       accCode;
  logic [STAT_HOLD_W-1:0] holdBits;
  logic                   ovr;
  logic                   rdf, dr;
  logic                   ctrlWr, statWr, lineRd, overrunHit;
  logic                   atTrig;
  logic [LVL_W-1:0]       cntWide, cntNextWide;
  logic                   unusedBits;

  assign unusedBits = ^{regWdata[REG_W-1:ACC_LSB+ACC_W], regWdata[TRIG_LSB+TRIG_W],
                        regWdata[STAT_HOLD_LSB-1:0]};

  assign ctrlWr     = regWr && (regSel == REG_CTRL);
  assign statWr     = regWr && (regSel == REG_STAT);
  assign lineRd     = regRd && (regSel == REG_LINE);
  assign overrunHit = rxValid && full;

  assign strobe.push = rxValid;
  assign strobe.pop  = regRd && (regSel == REG_DATA);

  assign cntWide      = LVL_W'(count);
  assign cntNextWide  = LVL_W'(countNext);
  assign trigCodeNext = ctrlWr ? regWdata[TRIG_LSB +: TRIG_W] : trigCode;
  assign atTrig       = cntNextWide >= trigLevel(trigCodeNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigCode <= '0;
      accCode  <= '0;
      holdBits <= '1;
      ovr      <= 1'b0;
      rdf      <= 1'b0;
      dr       <= 1'b0;
    end else begin
      if (ctrlWr) begin
        trigCode <= regWdata[TRIG_LSB +: TRIG_W];
        accCode  <= regWdata[ACC_LSB +: ACC_W];
      end
      if (statWr)
        holdBits <= regWdata[STAT_HOLD_LSB +: STAT_HOLD_W];
      if (overrunHit)
        ovr <= 1'b1;
      else if (lineRd)
        ovr <= 1'b0;
      rdf <= atTrig;
      dr  <= !atTrig && (countNext != '0);
    end
  end

  assign rxReady  = cntWide < acceptLimit(accCode);
  assign trigFlag = rdf;
  assign dataFlag = dr;

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      REG_DATA: regRdata = REG_W'(headData);
      REG_STAT: begin
        regRdata[STAT_HOLD_LSB +: STAT_HOLD_W] = holdBits;
        regRdata[STAT_RDF] = rdf;
        regRdata[STAT_DR]  = dr;
      end
      REG_CTRL: begin
        regRdata[TRIG_LSB +: TRIG_W] = trigCode;
        regRdata[ACC_LSB +: ACC_W]   = accCode;
      end
      default: regRdata[LINE_OVR] = ovr;
    endcase
  end

  // R3: a byte hitting a full queue latches the overrun bit
  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    overrunHit |=> ovr);

  // R8: a line-status read with no new overrun clears the bit
  a_r8_line_clears: assert property (@(posedge clk) disable iff (!rstN)
    (lineRd && !overrunHit) |=> !ovr);

  // R5: trigger and data-present flags never both set
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdf && dr));

  // R6: data-present flag only with a non-empty queue
  a_r6_dr_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    dr |-> !empty);

  // R7: a full queue never signals ready
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !rxReady);

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int REG_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              rxReady,
  output logic              trigFlag,
  output logic              dataFlag
);

  fifoStrobe_t       strobe;
  logic [DATA_W-1:0] headData;
  logic [CNT_W-1:0]  count, countNext;
  logic              full, empty;

  rxf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pushData  (rxData),
    .headData  (headData),
    .count     (count),
    .countNext (countNext),
    .full      (full),
    .empty     (empty)
  );

  rxf_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxValid   (rxValid),
    .regSel    (regSel),
    .regRd     (regRd),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .headData  (headData),
    .count     (count),
    .countNext (countNext),
    .full      (full),
    .empty     (empty),
    .strobe    (strobe),
    .regRdata  (regRdata),
    .rxReady   (rxReady),
    .trigFlag  (trigFlag),
    .dataFlag  (dataFlag)
  );

endmodule

// File: tb/tb_rx_fifo_trig.sv
module tb_rx_fifo_trig;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic [1:0]  regSel = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        rxReady, trigFlag, dataFlag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_fifo_trig dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .rxReady(rxReady), .trigFlag(trigFlag), .dataFlag(dataFlag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    regSel = sel; regWr = 1'b1; regWdata = val;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rxValid = 1'b1; rxData = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // push and register read in the same cycle
  task automatic pushRead(input logic [1:0] sel, input logic [7:0] d, output logic [15:0] val);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; regSel = sel; regRd = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    rxValid = 1'b0; regRd = 1'b0;
  endtask

  function automatic int trigLvl(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int accLim(input int code);
    if (code == 0) return 15;
    if (code == 1) return 1;
    return 2 * code;
  endfunction

  function automatic logic [15:0] expStat(input int n, input int trg, input logic [1:0] hold);
    logic [15:0] s;
    s = {9'd0, hold, 5'd0};
    if (n >= trigLvl(trg)) s[1] = 1'b1;
    else if (n > 0) s[0] = 1'b1;
    return s;
  endfunction

  task automatic checkLevel(input string req, input int n, input int trg, input int acc);
    logic [15:0] v;
    logic [15:0] e;
    e = expStat(n, trg, 2'b11);
    regRead(2'd1, v);
    chk(req, v, e);
    chk(req, {14'd0, trigFlag, dataFlag}, {14'd0, e[1], e[0]});
    chk("R7 ready", {15'd0, rxReady}, {15'd0, 1'(n < accLim(acc))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd1, v); chk("R1 status", v, 16'h0060);
    regRead(2'd2, v); chk("R1 control", v, 16'h0000);
    regRead(2'd3, v); chk("R1 line", v, 16'h0000);
    chk("R1 ready", {15'd0, rxReady}, 16'd1);
    chk("R1 flags", {14'd0, trigFlag, dataFlag}, 16'd0);

    // R11 holding bits, other status bits ignored
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, v); chk("R11 clear hold", v, 16'h0000);
    regWrite(2'd1, 16'hFFFF);
    regRead(2'd1, v); chk("R11 set hold only", v, 16'h0060);

    // Sweep every accept and trigger code
    for (int acc = 0; acc < 8; acc++) begin
      for (int trg = 0; trg < 4; trg++) begin
        int combo;
        combo = acc * 4 + trg;
        regWrite(2'd2, 16'((acc << 9) | (trg << 6)) | 16'hF03F);
        regRead(2'd2, v);
        chk("R12 control readback", v, 16'((acc << 9) | (trg << 6)));
        for (int n = 0; n <= 16; n++) begin
          checkLevel("R4 R5 R6 fill", n, trg, acc);
          push(8'(combo * 16 + n + 5));
        end
        // the 17th push was dropped
        regRead(2'd3, v); chk("R3 overrun", v, 16'h0001);
        regRead(2'd3, v); chk("R8 cleared", v, 16'h0000);
        checkLevel("R3 still full", 16, trg, acc);
        for (int i = 0; i < 16; i++) begin
          regRead(2'd0, v);
          chk("R2 order", v, {8'd0, 8'(combo * 16 + i + 5)});
          checkLevel("R5 R6 drain", 15 - i, trg, acc);
        end
        regRead(2'd0, v); chk("R9 empty read", v, 16'h0000);
        checkLevel("R9 no change", 0, trg, acc);
      end
    end

    // R10 trigger change with data held
    regWrite(2'd2, 16'h0000);
    for (int i = 0; i < 8; i++) push(8'(8'hA0 + i));
    regRead(2'd1, v); chk("R10 trig1", v, 16'h0062);
    regWrite(2'd2, 16'h00C0);
    regRead(2'd1, v); chk("R10 trig14", v, 16'h0061);
    regWrite(2'd2, 16'h0080);
    regRead(2'd1, v); chk("R10 trig8", v, 16'h0062);
    for (int i = 0; i < 8; i++) regRead(2'd0, v);

    // R3 push into full queue while popping
    regWrite(2'd2, 16'h0000);
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    pushRead(2'd0, 8'hEE, v);
    chk("R3 pop head", v, 16'h0040);
    chk("R7 at 15 limit 15", {15'd0, rxReady}, 16'd0);
    regRead(2'd3, v); chk("R3 overrun with pop", v, 16'h0001);
    for (int i = 1; i < 16; i++) begin
      regRead(2'd0, v); chk("R3 R2 drop order", v, {8'd0, 8'(8'h40 + i)});
    end
    regRead(2'd0, v); chk("R3 no extra byte", v, 16'h0000);

    // R8 overrun arriving during line-status read
    for (int i = 0; i < 16; i++) push(8'(i));
    pushRead(2'd3, 8'h77, v);
    chk("R8 read value", v, 16'h0000);
    regRead(2'd3, v); chk("R8 overrun wins", v, 16'h0001);
    regRead(2'd3, v); chk("R8 then clear", v, 16'h0000);
    for (int i = 0; i < 16; i++) regRead(2'd0, v);

    // R9 push together with empty read
    pushRead(2'd0, 8'h5A, v);
    chk("R9 empty read with push", v, 16'h0000);
    regRead(2'd1, v); chk("R9 push kept", v, 16'h0062);
    regRead(2'd0, v); p = v[7:0];
    chk("R9 stored byte", {8'd0, p}, 16'h005A);
    regRead(2'd1, v); chk("R6 empty again", v, 16'h0060);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule